// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that software drives through four 32-bit word registers on a simple synchronous bus. The counting logic runs from a slow, free-running tick clock that is separate from the bus clock. A prescaler divides the tick clock. Each prescaled tick decrements a down-counter. When the counter has run out, the block raises a reset request for exactly one tick-clock cycle and loads the counter again from the reload value.

Software controls the block by writing 32-bit magic values to the command register. One value starts counting, one refreshes the counter, and one opens the divider and reload registers for writing. A write of any other value to the command register closes them again. Once counting has started, software cannot stop it. Only the block's reset stops it.

Every accepted divider or reload write is carried into the tick domain by a toggle handshake. While that transfer is in flight, a status bit stays set and further writes to the same register are dropped.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the divider code reads 0, the reload value reads 0xFFF, the status word reads 0 and no reset request is raised until counting is started.
- R2: Word offsets are fixed: command at 0x0, divider at 0x4, reload at 0x8 and status at 0xC. The command register reads 0. Writes to the status register have no effect.
- R3: A command write of 0x0000_5555 opens the divider and reload registers. While they are closed, writes to them are ignored.
- R4: A command write of any value other than 0x0000_5555 closes the divider and reload registers.
- R5: The divider register keeps only wdata bits [2:0]. Code k in 0..6 divides the tick clock by 4·2^k, and code 7 divides it by 256.
- R6: The reload register keeps only wdata bits [11:0].
- R7: A command write of 0x0000_CCCC starts counting. Between two consecutive reset requests there are exactly (reload+1)·divisor tick cycles. Before the start, no reset request occurs.
- R8: A command write of 0x0000_AAAA restarts the prescaler and reloads the counter. If software refreshes more often than the timeout, no reset request occurs. After the last refresh, a request follows within (reload+1)·divisor plus the crossing latency.
- R9: A reset request is high for exactly one tick-clock cycle.
- R10: Once started, the watchdog keeps running, whatever is later written to the command register.
- R11: Status bit 0 (divider) and status bit 1 (reload) are set from an accepted write until the tick domain has taken the new value. Writes to a register whose bit is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tick_clk | input | 1 | Slow free-running counting clock |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| reset_req | output | 1 | One tick-cycle reset request on timeout |

## Verification
The embedded assertions check these rules on every cycle:
- a write while the registers are locked or while a transfer is pending leaves the stored value unchanged;
- the started state never clears;
- each handshake produces single-cycle destination pulses;
- a reset request is never wider than one cycle and only follows a counter at zero.

The actual timeout lengths for each divider code and reload value, and the suppression of requests by regular refreshes, come from a timeline that only the bench's scenarios show. The same holds for the status bits rising and clearing around a crossing. The bench shows these by measuring intervals in tick cycles.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

   localparam logic [31:0] CMD_REFRESH = 32'h0000_AAAA;
   localparam logic [31:0] CMD_START   = 32'h0000_CCCC;
   localparam logic [31:0] CMD_OPEN    = 32'h0000_5555;

   localparam int OFS_CMD = 'h0;
   localparam int OFS_DIV = 'h4;
   localparam int OFS_RLD = 'h8;
   localparam int OFS_STS = 'hC;

   localparam int STS_DIV_BIT = 0;
   localparam int STS_RLD_BIT = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CMD,
      SEL_DIV,
      SEL_RLD,
      SEL_STS
   } wdg_sel_e;

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_handshake.sv
module wdg_handshake #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic src_go,
   output logic src_busy,
   output logic dst_pulse
);
   logic req_tgl, ack_seen, req_seen, dst_last;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)                    req_tgl <= 1'b0;
      else if (src_go && !src_busy)  req_tgl <= ~req_tgl;
   end

   wdg_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(dst_clk), .rst_n(rst_n), .d(req_tgl), .q(req_seen));

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) dst_last <= 1'b0;
      else        dst_last <= req_seen;
   end

   assign dst_pulse = req_seen ^ dst_last;

   wdg_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(src_clk), .rst_n(rst_n), .d(dst_last), .q(ack_seen));

   assign src_busy = req_tgl ^ ack_seen;

   // R11: the destination sees each transfer as one single-cycle pulse
   a_r11_single_pulse: assert property (@(posedge dst_clk) disable iff (!rst_n)
      dst_pulse |=> !dst_pulse);

   // R11: busy only rises because a transfer was launched
   a_r11_busy_from_go: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(src_busy) |-> $past(src_go));
endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
   import keyed_wdog_pkg::*;
#(
   parameter int               DATA_W  = 32,
   parameter int               ADDR_W  = 4,
   parameter int               CNT_W   = 12,
   parameter int               CODE_W  = 3,
   parameter logic [CNT_W-1:0] RLD_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              div_busy,
   input  logic              rld_busy,
   output logic [DATA_W-1:0] rdata,
   output logic [CODE_W-1:0] div_q,
   output logic [CNT_W-1:0]  rld_q,
   output logic              run_q,
   output logic              div_go,
   output logic              rld_go,
   output logic              kick_go
);
   wdg_sel_e which;
   logic     opened;
   logic     cmd_wr;
   logic     unused_hi;

   always_comb begin
      if      (addr == ADDR_W'(OFS_CMD)) which = SEL_CMD;
      else if (addr == ADDR_W'(OFS_DIV)) which = SEL_DIV;
      else if (addr == ADDR_W'(OFS_RLD)) which = SEL_RLD;
      else if (addr == ADDR_W'(OFS_STS)) which = SEL_STS;
      else                               which = SEL_NONE;
   end

   assign cmd_wr  = sel && wr && (which == SEL_CMD);
   assign kick_go = cmd_wr && (wdata == DATA_W'(CMD_REFRESH));
   assign div_go  = sel && wr && (which == SEL_DIV) && opened && !div_busy;
   assign rld_go  = sel && wr && (which == SEL_RLD) && opened && !rld_busy;
   assign unused_hi = ^wdata[DATA_W-1:CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opened <= 1'b0;
         run_q  <= 1'b0;
         div_q  <= '0;
         rld_q  <= RLD_INIT;
      end else begin
         if (cmd_wr) opened <= (wdata == DATA_W'(CMD_OPEN));
         if (cmd_wr && (wdata == DATA_W'(CMD_START))) run_q <= 1'b1;
         if (div_go) div_q <= wdata[CODE_W-1:0];
         if (rld_go) rld_q <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (which)
         SEL_DIV: rdata[CODE_W-1:0] = div_q;
         SEL_RLD: rdata[CNT_W-1:0]  = rld_q;
         SEL_STS: begin
            rdata[STS_DIV_BIT] = div_busy;
            rdata[STS_RLD_BIT] = rld_busy;
         end
         default: rdata = '0;
      endcase
   end

   // R3: closed registers ignore writes
   a_r3_locked_div: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && which == SEL_DIV && !opened) |=> $stable(div_q));
   a_r3_locked_rld: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && which == SEL_RLD && !opened) |=> $stable(rld_q));
   // R11: a pending transfer freezes its register
   a_r11_pending_div: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && which == SEL_DIV && div_busy) |=> $stable(div_q));
   a_r11_pending_rld: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && which == SEL_RLD && rld_busy) |=> $stable(rld_q));
   // R10: the started state never clears
   a_r10_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);
endmodule

// File: rtl/wdg_tick_core.sv
module wdg_tick_core #(
   parameter int               CNT_W       = 12,
   parameter int               CODE_W      = 3,
   parameter int               DIV_LOG_MIN = 2,
   parameter int               DIV_LOG_MAX = 8,
   parameter int               STAGES      = 2,
   parameter logic [CNT_W-1:0] RLD_INIT    = '1
) (
   input  logic              tick_clk,
   input  logic              rst_n,
   input  logic              run_async,
   input  logic [CODE_W-1:0] div_in,
   input  logic [CNT_W-1:0]  rld_in,
   input  logic              div_take,
   input  logic              rld_take,
   input  logic              kick,
   output logic              reset_req
);
   localparam int PC_W   = DIV_LOG_MAX;
   localparam int NCODES = 2 ** CODE_W;

   logic              run_s, run_d, start_ev, restart;
   logic [CODE_W-1:0] div_t;
   logic [CNT_W-1:0]  rld_t, cnt;
   logic [PC_W-1:0]   pcnt, lim;
   logic [PC_W-1:0]   lim_tab [NCODES];
   logic              tick;

   for (genvar c = 0; c < NCODES; c++) begin : g_lim
      localparam int LG = (DIV_LOG_MIN + c > DIV_LOG_MAX) ? DIV_LOG_MAX : DIV_LOG_MIN + c;
      assign lim_tab[c] = PC_W'((1 << LG) - 1);
   end

   wdg_sync #(.STAGES(STAGES)) u_run_sync (
      .clk(tick_clk), .rst_n(rst_n), .d(run_async), .q(run_s));

   assign start_ev = run_s && !run_d;
   assign restart  = start_ev || kick;
   assign lim      = lim_tab[div_t];
   assign tick     = run_s && !restart && (pcnt >= lim);

   always_ff @(posedge tick_clk or negedge rst_n) begin
      if (!rst_n) begin
         run_d     <= 1'b0;
         div_t     <= '0;
         rld_t     <= RLD_INIT;
         pcnt      <= '0;
         cnt       <= RLD_INIT;
         reset_req <= 1'b0;
      end else begin
         run_d <= run_s;
         if (div_take) div_t <= div_in;
         if (rld_take) rld_t <= rld_in;

         if (!run_s || restart || tick) pcnt <= '0;
         else                           pcnt <= pcnt + 1'b1;

         if (restart)                cnt <= rld_t;
         else if (tick && cnt == '0) cnt <= rld_t;
         else if (tick)              cnt <= cnt - 1'b1;

         reset_req <= tick && (cnt == '0);
      end
   end

   // R9: a request never lasts two cycles
   a_r9_one_cycle: assert property (@(posedge tick_clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   // R7: a request only follows an exhausted counter
   a_r7_from_zero: assert property (@(posedge tick_clk) disable iff (!rst_n)
      reset_req |-> ($past(cnt) == '0));
   // R7: nothing is requested before counting runs
   a_r7_idle_quiet: assert property (@(posedge tick_clk) disable iff (!rst_n)
      !run_d |-> !reset_req);
   // R5: prescaler never passes the largest divisor
   a_r5_pcnt_bound: assert property (@(posedge tick_clk) disable iff (!rst_n)
      pcnt <= PC_W'((1 << DIV_LOG_MAX) - 1));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int CNT_W       = 12,
   parameter int CODE_W      = 3,
   parameter int DIV_LOG_MIN = 2,
   parameter int DIV_LOG_MAX = 8,
   parameter int SYNC_N      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_clk,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              reset_req
);
   localparam logic [CNT_W-1:0] RLD_INIT = '1;

   if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt
      $error("keyed_wdog: CNT_W must be at least 2 and below DATA_W");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("keyed_wdog: DATA_W must hold the 16-bit command codes");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("keyed_wdog: ADDR_W must span four words");
   end
   if (CODE_W < 1 || CODE_W > 4 || CODE_W > CNT_W) begin : g_bad_code
      $error("keyed_wdog: CODE_W out of range");
   end
   if (DIV_LOG_MIN < 1 || DIV_LOG_MAX < DIV_LOG_MIN || DIV_LOG_MAX > 16) begin : g_bad_div
      $error("keyed_wdog: divider range invalid");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("keyed_wdog: at least two synchronizer stages required");
   end

   logic              div_busy, rld_busy, run_q;
   logic              div_go, rld_go, kick_go;
   logic              div_take, rld_take, kick_t;
   logic              kick_busy_unused;
   logic [CODE_W-1:0] div_q;
   logic [CNT_W-1:0]  rld_q;

   wdg_bus_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W), .RLD_INIT(RLD_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .div_busy(div_busy), .rld_busy(rld_busy), .rdata(bus_rdata),
      .div_q(div_q), .rld_q(rld_q), .run_q(run_q), .div_go(div_go), .rld_go(rld_go),
      .kick_go(kick_go));

   wdg_handshake #(.STAGES(SYNC_N)) u_hs_div (
      .src_clk(clk), .dst_clk(tick_clk), .rst_n(rst_n), .src_go(div_go),
      .src_busy(div_busy), .dst_pulse(div_take));

   wdg_handshake #(.STAGES(SYNC_N)) u_hs_rld (
      .src_clk(clk), .dst_clk(tick_clk), .rst_n(rst_n), .src_go(rld_go),
      .src_busy(rld_busy), .dst_pulse(rld_take));

   wdg_handshake #(.STAGES(SYNC_N)) u_hs_kick (
      .src_clk(clk), .dst_clk(tick_clk), .rst_n(rst_n), .src_go(kick_go),
      .src_busy(kick_busy_unused), .dst_pulse(kick_t));

   wdg_tick_core #(
      .CNT_W(CNT_W), .CODE_W(CODE_W), .DIV_LOG_MIN(DIV_LOG_MIN),
      .DIV_LOG_MAX(DIV_LOG_MAX), .STAGES(SYNC_N), .RLD_INIT(RLD_INIT)
   ) u_core (
      .tick_clk(tick_clk), .rst_n(rst_n), .run_async(run_q), .div_in(div_q),
      .rld_in(rld_q), .div_take(div_take), .rld_take(rld_take), .kick(kick_t),
      .reset_req(reset_req));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
   logic        clk = 1'b0;
   logic        tick_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        reset_req;

   int checks = 0;
   int errors = 0;
   int unsigned tck_n = 0;
   int unsigned t_last = 0;
   int unsigned t_prev = 0;
   int pulse_n = 0;
   int width_bad = 0;
   logic prev_req = 1'b0;

   always #2  clk = ~clk;
   always #12 tick_clk = ~tick_clk;

   keyed_wdog u_dut (
      .clk(clk), .rst_n(rst_n), .tick_clk(tick_clk), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .reset_req(reset_req));

   always @(posedge tick_clk) tck_n <= tck_n + 1;

   always @(negedge tick_clk) begin
      if (reset_req) begin
         if (prev_req) width_bad = width_bad + 1;
         t_prev  = t_last;
         t_last  = tck_n;
         pulse_n = pulse_n + 1;
      end
      prev_req = reset_req;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      s = 32'h1;
      while (s != 0) bread(4'hC, s);
   endtask

   task automatic wait_tck(input int n);
      repeat (n) @(posedge tick_clk);
   endtask

   task automatic measure(output int unsigned p);
      int n0;
      wait_idle();
      n0 = pulse_n;
      while (pulse_n < n0 + 2) @(posedge clk);
      p = t_last - t_prev;
   endtask

   function automatic int unsigned div_of(input int code);
      return (code >= 6) ? 256 : (4 << code);
   endfunction

   task automatic setup(input int code, input int rld);
      bwrite(4'h0, 32'h0000_5555);
      bwrite(4'h4, code);
      bwrite(4'h8, rld);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int unsigned p;
      int n0;
      int unsigned t0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // R1 reset state, R2 offsets
      bread(4'h4, r); chk("R1 divider reset", r, 32'h0);
      bread(4'h8, r); chk("R1 reload reset", r, 32'hFFF);
      bread(4'hC, r); chk("R1 status reset", r, 32'h0);
      bread(4'h0, r); chk("R2 command reads zero", r, 32'h0);

      // R3 closed registers ignore writes
      bwrite(4'h8, 32'h5); bread(4'h8, r); chk("R3 locked reload", r, 32'hFFF);
      bwrite(4'h4, 32'h3); bread(4'h4, r); chk("R3 locked divider", r, 32'h0);
      bread(4'hC, r); chk("R3 locked no transfer", r, 32'h0);

      // R4 other command relocks
      bwrite(4'h0, 32'h0000_5555);
      bwrite(4'h0, 32'h0000_1234);
      bwrite(4'h8, 32'h5); bread(4'h8, r); chk("R4 relocked reload", r, 32'hFFF);

      // R5 low three bits kept; R11 pending bit and dropped write
      bwrite(4'h0, 32'h0000_5555);
      bwrite(4'h4, 32'h0000_000A);
      bread(4'hC, r); chk("R11 divider pending bit0", r, 32'h1);
      bwrite(4'h4, 32'h5);
      wait_idle();
      bread(4'h4, r); chk("R5 divider field low bits", r, 32'h2);

      // R6 twelve-bit reload; R11 bit1
      bwrite(4'h8, 32'h00AB_C123);
      bread(4'hC, r); chk("R11 reload pending bit1", r, 32'h2);
      bwrite(4'h8, 32'h7);
      wait_idle();
      bread(4'h8, r); chk("R6 reload field", r, 32'h123);
      bread(4'hC, r); chk("R11 status clears", r, 32'h0);

      // R2 status not writable
      bwrite(4'hC, 32'hFF); bread(4'hC, r); chk("R2 status write ignored", r, 32'h0);

      // R7 stopped: no requests
      setup(0, 0);
      wait_idle();
      wait_tck(100);
      chk("R7 no request before start", pulse_n, 0);

      bwrite(4'h0, 32'h0000_CCCC);

      // R5 divider sweep, reload 1
      for (int c = 0; c < 8; c++) begin
         setup(c, 1);
         measure(p);
         chk($sformatf("R5 period code %0d", c), p, 2 * div_of(c));
      end

      // R7 reload sweep, code 1
      for (int rl = 0; rl < 7; rl++) begin
         setup(1, rl);
         measure(p);
         chk($sformatf("R7 period reload %0d", rl), p, (rl + 1) * 8);
      end

      // R8 refresh holds off requests
      setup(0, 15);
      measure(p);
      chk("R8 base period", p, 64);
      bwrite(4'h0, 32'h0000_AAAA);
      wait_tck(5);
      n0 = pulse_n;
      for (int k = 0; k < 30; k++) begin
         bwrite(4'h0, 32'h0000_AAAA);
         wait_tck(20);
      end
      chk("R8 no request while refreshed", pulse_n, n0);
      bwrite(4'h0, 32'h0000_AAAA);
      t0 = tck_n;
      n0 = pulse_n;
      while (pulse_n == n0) @(posedge clk);
      chk("R8 timeout after last refresh in range",
          ((t_last - t0) >= 64 && (t_last - t0) <= 72) ? 32'h1 : 32'h0, 32'h1);

      // R10 cannot stop
      bwrite(4'h0, 32'h0000_0000);
      bwrite(4'h0, 32'h1234_5678);
      bwrite(4'h8, 32'h3);
      measure(p);
      chk("R10 still running after stop attempts", p, 64);
      bread(4'h8, r); chk("R10 reload untouched while locked", r, 32'hF);

      // R9 single-cycle width
      chk("R9 request width one cycle", width_bad, 0);
      chk("R9 requests observed", (pulse_n > 20) ? 32'h1 : 32'h0, 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule